// File: doc/BRIEF.md
# Write-Protected RAM Size Limiter

This block sits beside a single-cycle on-chip RAM of 4 KB (byte addresses 0x000 to 0xFFF) and decides how much of that RAM counts as usable. Software programs the usable size, either the full 4 KB or the lower 2 KB, through a 16-bit register port. The size register is guarded by a separate key register: a size write takes effect only while the key register holds 0x0096. Software can therefore shrink the RAM to match a smaller target device, and a stray write cannot change that setting.

Every RAM access address is also presented to the block. One cycle later the block reports whether the address lies at or above the configured limit. It also reports whether the address falls in the 64-byte window at the top of the full RAM (0xFC0 to 0xFFF), which is kept for debug use, while debug operation is enabled.

The register port is a plain strobe interface. An access is a `reg_sel` pulse carrying `reg_we`, `reg_addr` and `reg_wdata`. The block answers with `reg_ack` and, for reads, `reg_rdata` in the following cycle.

Top module: `memlim_top`

## Requirements
- R1: While `rst` is high at a clock edge, and after it, the size field returns to code 2 (4 KB) and the key register returns to 0x0000. After reset, reads return 0x0002 and 0x0000, and both flags are low.
- R2: `reg_ack` is high in exactly the cycle after each cycle with `reg_sel` high. For a read, `reg_rdata` is valid in that cycle. Addresses other than 0x5324 and 0x5326 read as 0x0000, and writing them changes no register.
- R3: The key register at 0x5324 stores all 16 written bits and reads them back. It keeps its value until it is written again, and size writes do not clear it.
- R4: A write to 0x5326 while the key register holds 0x0096 loads bits [1:0]. Code 3 selects 2 KB and code 2 selects 4 KB. With any other key value the write leaves the size unchanged.
- R5: An unlocked write to 0x5326 whose bits [1:0] are 0 or 1 (reserved codes) leaves the size unchanged.
- R6: A read of 0x5326 returns the 2-bit size code in bits [1:0] with bits [15:2] zero, whether or not the key is set.
- R7: In the cycle after `ram_req` is high, `oor_flag` is high exactly when `ram_addr` is at or above the limit: 0x800 for code 3, 0x1000 for code 2.
- R8: In the cycle after `ram_req` is high, `dbg_hit` is high exactly when `dbg_en` was high and `ram_addr` was in 0xFC0 to 0xFFF.
- R9: In the cycle after `ram_req` is low, both `oor_flag` and `dbg_hit` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 16 | Register byte address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, valid with `reg_ack` |
| reg_ack | output | 1 | Response, one cycle after `reg_sel` |
| ram_req | input | 1 | A RAM access is presented this cycle |
| ram_addr | input | 13 | RAM byte address of that access |
| dbg_en | input | 1 | Debug operation enabled |
| oor_flag | output | 1 | Previous access was beyond the configured size |
| dbg_hit | output | 1 | Previous access hit the debug window with debug enabled |

## Verification
The assertions assume that every input is at a known value at each clock edge and that `reg_sel` stays low while `rst` is high. They also assume that at most one register access is presented per cycle. The response check relates `reg_ack` to the previous cycle's strobe only outside reset. The stimulus keeps within these limits. It holds every input at zero through reset, changes inputs one time unit after a rising edge, and issues register and RAM accesses one at a time from sequential tasks.

// File: rtl/memlim_pkg.sv
package memlim_pkg;

  // 2-bit size code held in the size register
  typedef enum logic [1:0] {
    SZ_RSV0 = 2'd0,
    SZ_RSV1 = 2'd1,
    SZ_FULL = 2'd2,
    SZ_HALF = 2'd3
  } sz_code_e;

  function automatic logic code_legal(input logic [1:0] code);
    return (code == SZ_FULL) || (code == SZ_HALF);
  endfunction

endpackage

// File: rtl/memlim_regs.sv
module memlim_regs
  import memlim_pkg::*;
#(
  parameter int          AW        = 16,
  parameter int          DW        = 16,
  parameter logic [15:0] PROT_ADDR = 16'h5324,
  parameter logic [15:0] SIZE_ADDR = 16'h5326,
  parameter logic [15:0] KEY       = 16'h0096
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          ack,
  output sz_code_e      size_code,
  output logic          key_open
);

  localparam logic [AW-1:0] PROT_A = AW'(PROT_ADDR);
  localparam logic [AW-1:0] SIZE_A = AW'(SIZE_ADDR);
  localparam logic [DW-1:0] KEY_V  = DW'(KEY);

  logic [DW-1:0] prot_q;
  sz_code_e      size_q;
  logic          hit_prot, hit_size;
  logic          wr_prot, wr_size;
  logic [DW-1:0] rd_mux;

  assign hit_prot = (addr == PROT_A);
  assign hit_size = (addr == SIZE_A);
  assign wr_prot  = sel && we && hit_prot;
  assign wr_size  = sel && we && hit_size && key_open && code_legal(wdata[1:0]);
  assign key_open = (prot_q == KEY_V);

  always_comb begin
    rd_mux = '0;
    if (hit_prot)      rd_mux = prot_q;
    else if (hit_size) rd_mux = {{(DW-2){1'b0}}, size_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prot_q <= '0;
      size_q <= SZ_FULL;
      ack    <= 1'b0;
      rdata  <= '0;
    end else begin
      ack   <= sel;
      rdata <= (sel && !we) ? rd_mux : '0;
      if (wr_prot) prot_q <= wdata;
      if (wr_size) size_q <= sz_code_e'(wdata[1:0]);
    end
  end

  assign size_code = size_q;

endmodule

// File: rtl/memlim_window.sv
module memlim_window
  import memlim_pkg::*;
#(
  parameter int FULL_BYTES = 4096,
  parameter int HALF_BYTES = 2048,
  parameter int DBG_BYTES  = 64,
  parameter int RAM_AW     = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  sz_code_e          size_code,
  input  logic              ram_req,
  input  logic [RAM_AW-1:0] ram_addr,
  input  logic              dbg_en,
  output logic              oor_flag,
  output logic              dbg_hit
);

  localparam logic [RAM_AW-1:0] FULL_LIM = RAM_AW'(FULL_BYTES);
  localparam logic [RAM_AW-1:0] HALF_LIM = RAM_AW'(HALF_BYTES);
  localparam logic [RAM_AW-1:0] DBG_LO   = RAM_AW'(FULL_BYTES - DBG_BYTES);
  localparam logic [RAM_AW-1:0] DBG_HI   = RAM_AW'(FULL_BYTES - 1);

  logic [RAM_AW-1:0] limit;
  logic              beyond;
  logic              in_dbg;

  assign limit  = (size_code == SZ_HALF) ? HALF_LIM : FULL_LIM;
  assign beyond = (ram_addr >= limit);

  generate
    if (DBG_BYTES > 0) begin : g_dbg
      assign in_dbg = (ram_addr >= DBG_LO) && (ram_addr <= DBG_HI);
    end else begin : g_nodbg
      assign in_dbg = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      oor_flag <= 1'b0;
      dbg_hit  <= 1'b0;
    end else begin
      oor_flag <= ram_req && beyond;
      dbg_hit  <= ram_req && dbg_en && in_dbg;
    end
  end

endmodule

// File: rtl/memlim_top.sv
module memlim_top
  import memlim_pkg::*;
#(
  parameter int          AW         = 16,
  parameter int          DW         = 16,
  parameter int          FULL_BYTES = 4096,
  parameter int          HALF_BYTES = 2048,
  parameter int          DBG_BYTES  = 64,
  parameter int          RAM_AW     = $clog2(FULL_BYTES) + 1,
  parameter logic [15:0] PROT_ADDR  = 16'h5324,
  parameter logic [15:0] SIZE_ADDR  = 16'h5326,
  parameter logic [15:0] KEY        = 16'h0096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              reg_ack,
  input  logic              ram_req,
  input  logic [RAM_AW-1:0] ram_addr,
  input  logic              dbg_en,
  output logic              oor_flag,
  output logic              dbg_hit
);

  sz_code_e size_code;
  logic     key_open;

  memlim_regs #(
    .AW(AW), .DW(DW), .PROT_ADDR(PROT_ADDR), .SIZE_ADDR(SIZE_ADDR), .KEY(KEY)
  ) u_regs (
    .clk(clk), .rst(rst), .sel(reg_sel), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .ack(reg_ack),
    .size_code(size_code), .key_open(key_open)
  );

  memlim_window #(
    .FULL_BYTES(FULL_BYTES), .HALF_BYTES(HALF_BYTES),
    .DBG_BYTES(DBG_BYTES), .RAM_AW(RAM_AW)
  ) u_win (
    .clk(clk), .rst(rst), .size_code(size_code), .ram_req(ram_req),
    .ram_addr(ram_addr), .dbg_en(dbg_en), .oor_flag(oor_flag), .dbg_hit(dbg_hit)
  );

endmodule

// File: rtl/memlim_chk.sv
module memlim_chk
  import memlim_pkg::*;
#(
  parameter int          AW         = 16,
  parameter int          FULL_BYTES = 4096,
  parameter int          HALF_BYTES = 2048,
  parameter int          RAM_AW     = 13,
  parameter logic [15:0] SIZE_ADDR  = 16'h5326
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_sel,
  input logic              reg_we,
  input logic [AW-1:0]     reg_addr,
  input logic              reg_ack,
  input logic              ram_req,
  input logic [RAM_AW-1:0] ram_addr,
  input logic              dbg_en,
  input logic              oor_flag,
  input logic              dbg_hit,
  input sz_code_e          size_code,
  input logic              key_open
);

  localparam logic [RAM_AW-1:0] FULL_LIM = RAM_AW'(FULL_BYTES);
  localparam logic [RAM_AW-1:0] HALF_LIM = RAM_AW'(HALF_BYTES);

  assert_ack_follows_R2: assert property (@(posedge clk) disable iff (rst)
    reg_sel |=> reg_ack);
  assert_no_ack_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !reg_sel |=> !reg_ack);
  assert_locked_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (reg_sel && reg_we && reg_addr == AW'(SIZE_ADDR) && !key_open) |=> $stable(size_code));
  assert_code_legal_R5: assert property (@(posedge clk) disable iff (rst)
    size_code == SZ_FULL || size_code == SZ_HALF);
  assert_oor_above_full_R7: assert property (@(posedge clk) disable iff (rst)
    (ram_req && ram_addr >= FULL_LIM) |=> oor_flag);
  assert_oor_below_half_R7: assert property (@(posedge clk) disable iff (rst)
    (ram_req && ram_addr < HALF_LIM) |=> !oor_flag);
  assert_dbg_gated_R8: assert property (@(posedge clk) disable iff (rst)
    !dbg_en |=> !dbg_hit);
  assert_idle_no_flag_R9: assert property (@(posedge clk) disable iff (rst)
    !ram_req |=> (!oor_flag && !dbg_hit));

endmodule

bind memlim_top memlim_chk #(
  .AW(AW), .FULL_BYTES(FULL_BYTES), .HALF_BYTES(HALF_BYTES),
  .RAM_AW(RAM_AW), .SIZE_ADDR(SIZE_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_ack(reg_ack), .ram_req(ram_req), .ram_addr(ram_addr), .dbg_en(dbg_en),
  .oor_flag(oor_flag), .dbg_hit(dbg_hit), .size_code(size_code), .key_open(key_open)
);

// File: tb/sim_memlim_top.sv
`timescale 1ns/1ps
module sim_memlim_top;

  localparam logic [15:0] PROT = 16'h5324;
  localparam logic [15:0] SIZE = 16'h5326;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_sel = 1'b0, reg_we = 1'b0;
  logic [15:0] reg_addr = '0, reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        reg_ack;
  logic        ram_req = 1'b0;
  logic [12:0] ram_addr = '0;
  logic        dbg_en = 1'b0;
  logic        oor_flag, dbg_hit;

  always #4 clk = ~clk;   // 125 MHz

  memlim_top u0 (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ack(reg_ack),
    .ram_req(ram_req), .ram_addr(ram_addr), .dbg_en(dbg_en),
    .oor_flag(oor_flag), .dbg_hit(dbg_hit)
  );

  int n_chk = 0, n_bad = 0;
  bit running = 0;
  bit done = 0;

  // scoreboard queues
  logic [15:0] rq_data[$];
  bit          rq_chk[$];
  string       rq_tag[$];
  logic [1:0]  fq_val[$];
  string       fq_tag[$];

  // bench model
  logic [15:0] m_prot = 16'h0000;
  logic [1:0]  m_size = 2'd2;

  function automatic logic [15:0] model_read(input logic [15:0] a);
    if (a == PROT) return m_prot;
    if (a == SIZE) return {14'd0, m_size};
    return 16'h0000;
  endfunction

  task automatic reg_write(input logic [15:0] a, input logic [15:0] d, input string tag);
    reg_sel = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    rq_data.push_back(16'h0); rq_chk.push_back(0); rq_tag.push_back(tag);
    if (a == PROT) m_prot = d;
    if (a == SIZE && m_prot == 16'h0096 && d[1]) m_size = d[1:0];
    #1 reg_sel = 0; reg_we = 0;
  endtask

  task automatic reg_read(input logic [15:0] a, input string tag);
    logic [15:0] e;
    e = model_read(a);
    reg_sel = 1; reg_we = 0; reg_addr = a;
    @(posedge clk);
    rq_data.push_back(e); rq_chk.push_back(1); rq_tag.push_back(tag);
    #1 reg_sel = 0;
  endtask

  task automatic ram_access(input logic [12:0] a, input logic de, input string tag);
    logic o, h;
    o = (a >= ((m_size == 2'd3) ? 13'h0800 : 13'h1000));
    h = de && (a >= 13'h0FC0) && (a <= 13'h0FFF);
    ram_req = 1; ram_addr = a; dbg_en = de;
    @(posedge clk);
    fq_val.push_back({o, h}); fq_tag.push_back(tag);
    #1 ram_req = 0; dbg_en = 0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (running && !rst) begin
      if (reg_ack) begin
        if (rq_data.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R2 unexpected ack: actual ack=1 expected ack=0");
        end else begin
          logic [15:0] e; bit c; string t;
          e = rq_data.pop_front(); c = rq_chk.pop_front(); t = rq_tag.pop_front();
          n_chk++;
          if (c && reg_rdata !== e) begin
            n_bad++;
            $display("FAIL %s read data: actual %h expected %h", t, reg_rdata, e);
          end
        end
      end else if (rq_data.size() != 0) begin
        n_chk++; n_bad++;
        $display("FAIL R2 missing ack: actual ack=0 expected ack=1");
        void'(rq_data.pop_front()); void'(rq_chk.pop_front()); void'(rq_tag.pop_front());
      end
      if (fq_val.size() != 0) begin
        logic [1:0] e; string t;
        e = fq_val.pop_front(); t = fq_tag.pop_front();
        n_chk++;
        if ({oor_flag, dbg_hit} !== e) begin
          n_bad++;
          $display("FAIL %s flags {oor,dbg}: actual %b expected %b", t, {oor_flag, dbg_hit}, e);
        end
      end else begin
        n_chk++;
        if ({oor_flag, dbg_hit} !== 2'b00) begin
          n_bad++;
          $display("FAIL R9 idle flags {oor,dbg}: actual %b expected 00", {oor_flag, dbg_hit});
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 0; running = 1;
    // R1 reset state
    reg_read(SIZE, "R1");
    reg_read(PROT, "R1");
    ram_access(13'h0FFF, 1'b0, "R1");
    // R4 locked write ignored
    reg_write(SIZE, 16'h0003, "R4");
    reg_read(SIZE, "R4");
    // R3 key register readback
    reg_write(PROT, 16'h1234, "R3");
    reg_read(PROT, "R3");
    reg_write(SIZE, 16'h0003, "R4");
    reg_read(SIZE, "R4");
    // R2 unmapped addresses
    reg_read(16'h5328, "R2");
    reg_write(16'h5322, 16'hFFFF, "R2");
    reg_read(PROT, "R2");
    // R4/R6 unlocked write with upper bits set
    reg_write(PROT, 16'h0096, "R4");
    reg_write(SIZE, 16'hFFFF, "R4");
    reg_read(SIZE, "R6");
    // R7 2 KB limit
    ram_access(13'h07FF, 1'b0, "R7");
    ram_access(13'h0800, 1'b0, "R7");
    ram_access(13'h0000, 1'b0, "R7");
    // R5 reserved codes
    reg_write(SIZE, 16'h0001, "R5");
    reg_read(SIZE, "R5");
    reg_write(SIZE, 16'h0000, "R5");
    reg_read(SIZE, "R5");
    ram_access(13'h0900, 1'b0, "R5");
    // R3 no relock after size writes
    reg_read(PROT, "R3");
    // back to 4 KB
    reg_write(SIZE, 16'h0002, "R4");
    reg_read(SIZE, "R4");
    ram_access(13'h0800, 1'b0, "R7");
    ram_access(13'h0FFF, 1'b0, "R7");
    ram_access(13'h1000, 1'b0, "R7");
    ram_access(13'h1FFF, 1'b0, "R7");
    // R8 debug window
    ram_access(13'h0FC0, 1'b1, "R8");
    ram_access(13'h0FBF, 1'b1, "R8");
    ram_access(13'h0FFF, 1'b1, "R8");
    ram_access(13'h1000, 1'b1, "R8");
    ram_access(13'h0FC0, 1'b0, "R8");
    // R6 read while locked
    reg_write(PROT, 16'h0095, "R6");
    reg_write(SIZE, 16'h0003, "R4");
    reg_read(SIZE, "R6");
    reg_write(PROT, 16'h0096, "R4");
    reg_write(SIZE, 16'h0003, "R4");
    reg_write(PROT, 16'h0000, "R3");
    reg_read(SIZE, "R6");
    // both flags at once: 2 KB and debug window
    ram_access(13'h0FC0, 1'b1, "R8");
    ram_access(13'h07C0, 1'b1, "R7");
    // R1 reset mid-run restores defaults
    rst = 1;
    running = 0;
    @(posedge clk); #1 rst = 0;
    m_prot = 16'h0000; m_size = 2'd2;
    running = 1;
    reg_read(SIZE, "R1");
    reg_read(PROT, "R1");
    repeat (3) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule